// File: doc/BRIEF.md
# Double-Buffered Capture Channel Register Bank

This block holds the per-channel buffer and control registers for a four-channel frame-capture DMA. Every channel has two copies of its buffer set: a staging copy that software writes over a 32-bit register bus, and an active copy that drives the DMA engine. The set holds the buffer address (low and high words), the line stride, the buffer length and the channel control word. Staging writes change nothing the engine sees until software writes the low address word. That write marks the staged set as pending, and the whole set then moves into the active copy in one cycle.

A pending set is normally taken at the channel's next frame start strobe. If the channel's active control has auto-arm set, a frame end strobe also takes it, so the channel moves straight to the new buffer. If the staged control word has the force bit set, the set is taken on the cycle after the commit write, whatever the frame timing. Software uses this to stop a channel mid-frame: it writes a control word that holds only force, then writes the low address word. The frame size and compression control registers are single copies and take effect as soon as they are written. Address, stride and length are held in 16-byte units and are presented to the engine as byte quantities.

Top module: `capdma_chan_regs`

## Requirements
- R1: After reset every register reads 0, and `ch_pending`, `ch_armed` and all active outputs are 0.
- R2: Channel c uses these word offsets: c*0x40 plus 0x28 for control, 0x2C for address low, 0x30 for stride, 0x34 for length, 0x3C for address high, 0x40 for frame size and 0x44 for compression. A read returns the staged value. A write to control, stride, length or address high changes no active output and does not set pending.
- R3: A write to the address low offset sets that channel's pending flag from the next cycle on.
- R4: With no force and no auto-arm frame end, a pending set stays pending until a frame start strobe on its own channel. At that clock edge all five staged values move to the active outputs and pending clears. A frame start on another channel has no effect.
- R5: When the staged control has force (bit 3), the pending set is taken at the clock edge that follows the commit write, with no strobe.
- R6: A take sets `ch_armed` to the DMA enable bit (bit 0) of the control word it brings in. A force take with enable 0 stops the channel.
- R7: When a frame end strobe arrives on a channel whose active control has auto-arm (bit 4) and a set is pending, the set is taken at that edge and the channel stays armed on the new buffer.
- R8: A frame end with no take clears `ch_armed` and leaves the active buffer values unchanged.
- R9: `act_base` equals {address high, address low} shifted left by 4 and cut to ADDR_W bits. `act_stride` and `act_len` equal the register values shifted left by 4.
- R10: Frame size (height in 31:16, width in 15:0) and compression control take effect on their outputs immediately, without a commit. `act_mode` is 0 when frame size is 0. Otherwise it is bits 2:1 of the active control.
- R11: A commit write in the same cycle as a take leaves pending set. The newly written address is taken at the next take.
- R12: A write to any offset outside the map changes no register, and a read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| frame_start | input | NCH | Frame start strobe per channel |
| frame_end | input | NCH | Frame end strobe per channel |
| ch_pending | output | NCH | Staged set waiting to be taken |
| ch_armed | output | NCH | Channel has a buffer to capture into |
| act_base | output | NCH*ADDR_W | Active buffer byte address |
| act_stride | output | NCH*36 | Active line stride in bytes |
| act_len | output | NCH*36 | Active buffer length in bytes |
| act_ctrl | output | NCH*32 | Active control word |
| act_mode | output | NCH*2 | Effective channel mode |
| frame_size | output | NCH*32 | Frame size register |
| comp_ctrl | output | NCH*32 | Compression control register |

## Verification
If the pending flag is wrong, a set is taken too early or never, and the wrong address appears on `act_base` at the edge of the strobe. A stuck staging register shows up on the bus read at once, but on the active outputs only after the next take. The force and overlap tests look at the cycle just before the take and the cycle just after it, so a take that happens one cycle off is caught. Each idle frame end is followed by a check of `ch_armed` in the same cycle.

// File: rtl/capdma_regs_pkg.sv
package capdma_regs_pkg;
  localparam int REG_W    = 32;
  localparam int UNIT_SH  = 4;
  localparam int SCALED_W = REG_W + UNIT_SH;
  localparam int FULL_AW  = 2 * REG_W + UNIT_SH;
  localparam int CH_STEP  = 64;
  localparam int CH_BASE  = 'h28;

  // control word fields
  localparam int CB_EN     = 0;
  localparam int CB_MODE_L = 1;
  localparam int CB_MODE_H = 2;
  localparam int CB_FORCE  = 3;
  localparam int CB_AUTO   = 4;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_ALO, SEL_STRIDE, SEL_LEN, SEL_AHI, SEL_FSIZE, SEL_COMP, SEL_NONE
  } reg_sel_e;

  function automatic logic [FULL_AW-1:0] units_to_addr(
    input logic [REG_W-1:0] hi, input logic [REG_W-1:0] lo);
    return {hi, lo, {UNIT_SH{1'b0}}};
  endfunction

  function automatic logic [SCALED_W-1:0] units_to_bytes(input logic [REG_W-1:0] v);
    return {v, {UNIT_SH{1'b0}}};
  endfunction

  function automatic logic [1:0] eff_mode(
    input logic [REG_W-1:0] ctrl, input logic [REG_W-1:0] fsize);
    return (fsize == '0) ? 2'd0 : ctrl[CB_MODE_H:CB_MODE_L];
  endfunction

  // word index inside a channel window -> register select
  function automatic reg_sel_e word_to_sel(input logic [3:0] w);
    case (w)
      4'd0:    return SEL_CTRL;
      4'd1:    return SEL_ALO;
      4'd2:    return SEL_STRIDE;
      4'd3:    return SEL_LEN;
      4'd5:    return SEL_AHI;
      4'd6:    return SEL_FSIZE;
      4'd7:    return SEL_COMP;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/capdma_addr_dec.sv
module capdma_addr_dec
  import capdma_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 9,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [CH_W-1:0] ch,
  output reg_sel_e        sel
);
  logic [AW-1:0] rel;
  logic          in_win;
  reg_sel_e      wsel;

  always_comb begin
    rel    = addr - AW'(CH_BASE);
    in_win = (addr >= AW'(CH_BASE)) && (rel < AW'(NCH * CH_STEP)) && (addr[1:0] == 2'b00);
    wsel   = word_to_sel(rel[5:2]);
    hit    = in_win && (wsel != SEL_NONE);
    sel    = hit ? wsel : SEL_NONE;
    ch     = hit ? rel[CH_W+5:6] : '0;
  end
endmodule

// File: rtl/capdma_chan.sv
module capdma_chan
  import capdma_regs_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [REG_W-1:0]    wdata,
  input  logic                frame_start,
  input  logic                frame_end,
  output logic [REG_W-1:0]    rd_data,
  output logic                pending,
  output logic                armed,
  output logic [ADDR_W-1:0]   act_base,
  output logic [SCALED_W-1:0] act_stride,
  output logic [SCALED_W-1:0] act_len,
  output logic [REG_W-1:0]    act_ctrl,
  output logic [1:0]          act_mode,
  output logic [REG_W-1:0]    frame_size,
  output logic [REG_W-1:0]    comp_ctrl
);
  logic [REG_W-1:0] stg_ctrl, stg_lo, stg_hi, stg_stride, stg_len;
  logic [REG_W-1:0] a_ctrl, a_lo, a_hi, a_stride, a_len;
  logic [REG_W-1:0] fsize_q, comp_q;
  logic             pending_q, armed_q;

  // named internal events
  logic wr_commit;
  logic take;
  logic idle_end;
  logic [FULL_AW-1:0] full_addr;

  assign wr_commit = wr_en && (sel == SEL_ALO);
  assign take      = pending_q && (stg_ctrl[CB_FORCE] || frame_start ||
                                   (frame_end && a_ctrl[CB_AUTO]));
  assign idle_end  = frame_end && !take;

  // staging copy and single-copy registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_ctrl <= '0; stg_lo <= '0; stg_hi <= '0; stg_stride <= '0; stg_len <= '0;
      fsize_q  <= '0; comp_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL:   stg_ctrl   <= wdata;
        SEL_ALO:    stg_lo     <= wdata;
        SEL_STRIDE: stg_stride <= wdata;
        SEL_LEN:    stg_len    <= wdata;
        SEL_AHI:    stg_hi     <= wdata;
        SEL_FSIZE:  fsize_q    <= wdata;
        SEL_COMP:   comp_q     <= wdata;
        default:    ;
      endcase
    end
  end

  // active copy, loaded as a whole on take
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ctrl <= '0; a_lo <= '0; a_hi <= '0; a_stride <= '0; a_len <= '0;
    end else if (take) begin
      a_ctrl   <= stg_ctrl;
      a_lo     <= stg_lo;
      a_hi     <= stg_hi;
      a_stride <= stg_stride;
      a_len    <= stg_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (wr_commit)  pending_q <= 1'b1;
      else if (take)  pending_q <= 1'b0;
      if (take)          armed_q <= stg_ctrl[CB_EN];
      else if (idle_end) armed_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:   rd_data = stg_ctrl;
      SEL_ALO:    rd_data = stg_lo;
      SEL_STRIDE: rd_data = stg_stride;
      SEL_LEN:    rd_data = stg_len;
      SEL_AHI:    rd_data = stg_hi;
      SEL_FSIZE:  rd_data = fsize_q;
      SEL_COMP:   rd_data = comp_q;
      default:    rd_data = '0;
    endcase
  end

  assign full_addr  = units_to_addr(a_hi, a_lo);
  assign act_base   = full_addr[ADDR_W-1:0];
  assign act_stride = units_to_bytes(a_stride);
  assign act_len    = units_to_bytes(a_len);
  assign act_ctrl   = a_ctrl;
  assign act_mode   = eff_mode(a_ctrl, fsize_q);
  assign frame_size = fsize_q;
  assign comp_ctrl  = comp_q;
  assign pending    = pending_q;
  assign armed      = armed_q;

  AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> pending); // R3
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(act_base) && $stable(act_ctrl)); // R2
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    pending && frame_start && !wr_commit |=> !pending); // R4
  AST_FORCE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    pending && stg_ctrl[CB_FORCE] && !wr_commit |=> !pending); // R5
  AST_ARM_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> armed == $past(stg_ctrl[CB_EN])); // R6
  AST_IDLE_END_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    idle_end |=> !armed && $stable(act_base)); // R8
  AST_OVERLAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    take && wr_commit |=> pending); // R11
endmodule

// File: rtl/capdma_chan_regs.sv
module capdma_chan_regs
  import capdma_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int AW     = 9,
  parameter int ADDR_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NCH-1:0]          frame_start,
  input  logic [NCH-1:0]          frame_end,
  output logic [NCH-1:0]          ch_pending,
  output logic [NCH-1:0]          ch_armed,
  output logic [NCH*ADDR_W-1:0]   act_base,
  output logic [NCH*36-1:0]       act_stride,
  output logic [NCH*36-1:0]       act_len,
  output logic [NCH*32-1:0]       act_ctrl,
  output logic [NCH*2-1:0]        act_mode,
  output logic [NCH*32-1:0]       frame_size,
  output logic [NCH*32-1:0]       comp_ctrl
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            hit;
  logic [CH_W-1:0] dec_ch;
  reg_sel_e        dec_sel;
  logic [REG_W-1:0] rd_arr [NCH];

  capdma_addr_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .addr(bus_addr), .hit(hit), .ch(dec_ch), .sel(dec_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = bus_wr && hit && (dec_ch == CH_W'(c));

    capdma_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (ch_wr),
      .sel        (dec_sel),
      .wdata      (bus_wdata),
      .frame_start(frame_start[c]),
      .frame_end  (frame_end[c]),
      .rd_data    (rd_arr[c]),
      .pending    (ch_pending[c]),
      .armed      (ch_armed[c]),
      .act_base   (act_base[c*ADDR_W +: ADDR_W]),
      .act_stride (act_stride[c*SCALED_W +: SCALED_W]),
      .act_len    (act_len[c*SCALED_W +: SCALED_W]),
      .act_ctrl   (act_ctrl[c*REG_W +: REG_W]),
      .act_mode   (act_mode[c*2 +: 2]),
      .frame_size (frame_size[c*REG_W +: REG_W]),
      .comp_ctrl  (comp_ctrl[c*REG_W +: REG_W])
    );
  end

  assign bus_rdata = hit ? rd_arr[dec_ch] : '0;

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> bus_rdata == '0); // R12
endmodule

// File: tb/test_capdma_chan_regs.sv
module test_capdma_chan_regs;
  localparam int NCH = 4;
  localparam int AW = 9;
  localparam int ADDR_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] frame_start = '0, frame_end = '0;
  logic [NCH-1:0] ch_pending, ch_armed;
  logic [NCH*ADDR_W-1:0] act_base;
  logic [NCH*36-1:0] act_stride, act_len;
  logic [NCH*32-1:0] act_ctrl, frame_size, comp_ctrl;
  logic [NCH*2-1:0] act_mode;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  capdma_chan_regs #(.NCH(NCH), .AW(AW), .ADDR_W(ADDR_W)) i_capdma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
    .frame_end(frame_end), .ch_pending(ch_pending), .ch_armed(ch_armed),
    .act_base(act_base), .act_stride(act_stride), .act_len(act_len),
    .act_ctrl(act_ctrl), .act_mode(act_mode), .frame_size(frame_size),
    .comp_ctrl(comp_ctrl)
  );

  function automatic logic [AW-1:0] off(int ch, int o);
    return AW'(ch * 64 + o);
  endfunction

  function automatic logic [63:0] exp_base(logic [31:0] hi, logic [31:0] lo);
    logic [63:0] full;
    full = (64'(hi) << 36) | (64'(lo) << 4);
    return full & ((64'd1 << ADDR_W) - 1);
  endfunction

  function automatic logic [63:0] base_of(int ch);
    return 64'(act_base[ch*ADDR_W +: ADDR_W]);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_fs(int ch);
    frame_start[ch] = 1'b1; tick(); frame_start[ch] = 1'b0;
  endtask

  task automatic pulse_fe(int ch);
    frame_end[ch] = 1'b1; tick(); frame_end[ch] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pending", 64'(ch_pending), 0);
    chk("R1 armed", 64'(ch_armed), 0);
    chk("R1 base ch2", base_of(2), 0);
    rd(off(0, 'h28), d); chk("R1 ctrl read", 64'(d), 0);
  endtask

  task automatic t_staging();
    logic [31:0] d;
    wr(off(1, 'h28), 32'h15A5);
    wr(off(1, 'h30), 32'h20);
    wr(off(1, 'h34), 32'h400);
    wr(off(1, 'h3C), 32'h3);
    chk("R2 no pending", 64'(ch_pending[1]), 0);
    chk("R2 act ctrl held", 64'(act_ctrl[32 +: 32]), 0);
    chk("R2 act stride held", 64'(act_stride[36 +: 36]), 0);
    rd(off(1, 'h28), d); chk("R2 ctrl readback", 64'(d), 64'h15A5);
    rd(off(1, 'h30), d); chk("R2 stride readback", 64'(d), 64'h20);
    // unmapped offsets
    wr(off(1, 'h38), 32'hFFFF);
    rd(off(1, 'h38), d); chk("R12 debug slot reads 0", 64'(d), 0);
    wr(9'h024, 32'hFFFF_FFFF);
    wr(9'h000, 32'hFFFF_FFFF);
    rd(9'h024, d); chk("R12 low offset reads 0", 64'(d), 0);
    rd(off(1, 'h28), d); chk("R12 ctrl untouched", 64'(d), 64'h15A5);
    chk("R12 no pending", 64'(ch_pending), 0);
  endtask

  task automatic t_start_commit();
    logic [31:0] d;
    wr(off(1, 'h2C), 32'h100);
    chk("R3 pending set", 64'(ch_pending[1]), 1);
    chk("R3 active not yet", base_of(1), 0);
    tick(); tick(); tick();
    chk("R4 waits for start", 64'(ch_pending[1]), 1);
    pulse_fs(0);
    chk("R4 other channel start ignored", 64'(ch_pending[1]), 1);
    chk("R4 other channel base held", base_of(1), 0);
    pulse_fs(1);
    chk("R4 pending cleared", 64'(ch_pending[1]), 0);
    chk("R9 base bytes", base_of(1), exp_base(32'h3, 32'h100));
    chk("R9 stride bytes", 64'(act_stride[36 +: 36]), 64'h20 * 16);
    chk("R9 len bytes", 64'(act_len[36 +: 36]), 64'h400 * 16);
    chk("R4 ctrl moved", 64'(act_ctrl[32 +: 32]), 64'h15A5);
    chk("R6 armed by enable", 64'(ch_armed[1]), 1);
    rd(off(1, 'h2C), d); chk("R2 addr low readback", 64'(d), 64'h100);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    chk("R10 zero size mode 0", 64'(act_mode[2 +: 2]), 0);
    wr(off(1, 'h40), 32'h00F0_0140);
    chk("R10 mode from ctrl", 64'(act_mode[2 +: 2]), 2);
    chk("R10 size port", 64'(frame_size[32 +: 32]), 64'h00F0_0140);
    wr(off(1, 'h44), 32'h0302_1234);
    chk("R10 comp port", 64'(comp_ctrl[32 +: 32]), 64'h0302_1234);
    rd(off(1, 'h44), d); chk("R10 comp readback", 64'(d), 64'h0302_1234);
    chk("R10 no pending", 64'(ch_pending[1]), 0);
  endtask

  task automatic t_idle_end();
    pulse_fe(1);
    chk("R8 disarmed", 64'(ch_armed[1]), 0);
    chk("R8 base held", base_of(1), exp_base(32'h3, 32'h100));
  endtask

  task automatic t_autoarm();
    wr(off(2, 'h28), 32'h11);
    wr(off(2, 'h2C), 32'hA);
    pulse_fs(2);
    chk("R6 ch2 armed", 64'(ch_armed[2]), 1);
    wr(off(2, 'h2C), 32'hB);
    chk("R7 pending before end", 64'(ch_pending[2]), 1);
    pulse_fe(2);
    chk("R7 base switched at end", base_of(2), 64'hB0);
    chk("R7 still armed", 64'(ch_armed[2]), 1);
    chk("R7 pending cleared", 64'(ch_pending[2]), 0);
    pulse_fe(2);
    chk("R8 end without set idles", 64'(ch_armed[2]), 0);
    chk("R8 base kept", base_of(2), 64'hB0);
  endtask

  task automatic t_force();
    wr(off(3, 'h28), 32'h1);
    wr(off(3, 'h2C), 32'h50);
    pulse_fs(3);
    chk("R6 ch3 armed", 64'(ch_armed[3]), 1);
    wr(off(3, 'h28), 32'h8);
    wr(off(3, 'h2C), 32'h0);
    chk("R5 pending after commit", 64'(ch_pending[3]), 1);
    chk("R5 ctrl not yet", 64'(act_ctrl[96 +: 32]), 64'h1);
    tick();
    chk("R5 ctrl taken", 64'(act_ctrl[96 +: 32]), 64'h8);
    chk("R5 base taken", base_of(3), 0);
    chk("R5 pending cleared", 64'(ch_pending[3]), 0);
    chk("R6 force stop disarms", 64'(ch_armed[3]), 0);
  endtask

  task automatic t_overlap();
    wr(off(0, 'h28), 32'h9);
    wr(off(0, 'h2C), 32'h5);
    wr(off(0, 'h2C), 32'h7);
    chk("R11 first set taken", base_of(0), 64'h50);
    chk("R11 pending kept", 64'(ch_pending[0]), 1);
    tick();
    chk("R11 second set taken", base_of(0), 64'h70);
    chk("R11 pending cleared", 64'(ch_pending[0]), 0);
    chk("R6 ch0 armed", 64'(ch_armed[0]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_staging();
    t_start_commit();
    t_mode();
    t_idle_end();
    t_autoarm();
    t_force();
    t_overlap();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule